// File: doc/BRIEF.md
# DRAM Bank Decoder with Parity and Refresh Scheduling

This block sits at the front of a fast-page-mode/EDO DRAM controller. It takes a 64-bit-word address and a per-bank size setting. It finds which of eight banks holds the word and splits the offset inside that bank into a row and a column. Banks are packed one after another from address zero in bank-number order. An unpopulated bank takes no address space. An address past the populated total is rejected with an error pulse, and no access is started for it.

On the data side, the block produces two even-parity bits for a 64-bit write word, one bit per 32-bit half. It checks the same two bits on read data. A single enable turns both the generation and the check off.

A refresh scheduler raises a CAS-before-RAS request at a programmable interval. The request waits for any access in progress to finish. It then wins over the next access. It drives the two refresh strobes in a fixed order: CAS first, then both together for a programmed hold, then RAS alone, then neither. The access length, the refresh interval and the hold are counted in controller clock cycles.

Top module: `dram_fe_top`

## Requirements
- R1: Bank k is sized by `cfg_bank_size[2k+1:2k]`. The codes are 0 = unpopulated (no space), 1 = 8 MB, 2 = 16 MB, 3 = 32 MB. Banks occupy the address space contiguously from word address 0 in ascending bank order.
- R2: One cycle after an accepted in-range request, `acc_bank` holds the bank index and `acc_cs` is one-hot on that bank. `acc_col` is word-offset bits [9:0] within the bank, and `acc_row` is word-offset bits [21:10] within the bank. `acc_cs` is non-zero exactly while `acc_busy` is high.
- R3: An accepted request whose address is at or beyond the populated total raises `addr_err` for exactly one cycle, one cycle after acceptance. No access is started: `acc_busy` and `acc_cs` stay low.
- R4: An in-range access holds `acc_busy` high for max(1, `cfg_acc_cycles`) cycles. `req_ready` is low throughout.
- R5: `wr_par[0]` is the XOR of `wr_data[31:0]` and `wr_par[1]` is the XOR of `wr_data[63:32]` (even parity). Both are 0 while `cfg_par_en` is 0.
- R6: One cycle after a cycle with `rd_valid` high, `par_err[i]` is 1 exactly when `cfg_par_en` is 1 and `rd_par[i]` differs from the XOR of half i of `rd_data`. In every other case it is 0.
- R7: With a non-zero `cfg_ref_interval` N, a refresh is requested every N cycles. On an idle bus with N longer than the strobe sequence, successive rises of `ref_cas` are exactly N cycles apart. N = 0 produces no refresh.
- R8: A refresh drives `ref_cas` alone for one cycle, then both strobes for max(1, `cfg_ref_hold`) cycles, then `ref_ras` alone for one cycle, then neither.
- R9: A pending refresh never drives a strobe during an access. It takes the bus before the next access, so refreshes keep occurring while `req_valid` is held high continuously.
- R10: After reset, `req_ready` is 1 and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_size | input | 16 | Two-bit size code per bank |
| cfg_par_en | input | 1 | Parity generation and check enable |
| cfg_acc_cycles | input | 4 | Access length in cycles (0 acts as 1) |
| cfg_ref_interval | input | 16 | Refresh period in cycles (0 disables) |
| cfg_ref_hold | input | 4 | Cycles both strobes stay asserted (0 acts as 1) |
| req_valid | input | 1 | Access request present |
| req_addr | input | 25 | 64-bit-word address |
| req_ready | output | 1 | Request is taken this cycle if valid |
| addr_err | output | 1 | One-cycle pulse for an out-of-range request |
| acc_busy | output | 1 | Access in progress |
| acc_cs | output | 8 | One-hot bank select during an access |
| acc_bank | output | 3 | Index of the accessed bank |
| acc_row | output | 12 | Row address within the bank |
| acc_col | output | 10 | Column address within the bank |
| wr_data | input | 64 | Write data word |
| wr_par | output | 2 | Generated parity, bit i for half i |
| rd_valid | input | 1 | Read data present |
| rd_data | input | 64 | Read data word |
| rd_par | input | 2 | Parity bits read with the data |
| par_err | output | 2 | Per-half parity mismatch flag |
| ref_cas | output | 1 | Refresh column strobe (active high) |
| ref_ras | output | 1 | Refresh row strobe (active high) |

## Verification
The bench targets the following corner cases:
- An unpopulated bank between two populated ones. A decoder that gave the empty bank space would shift every later bank's base.
- The last word of each bank and the first word past the total. An off-by-one limit would assign these to the wrong bank or accept the invalid address.
- A fully populated 256 MB map, where the top word must still fall in bank 7.
- Zero access length and zero hold, which must each behave as one cycle rather than wrap to a long count.
- Requests held high without a break. A scheduler that let accesses win would never refresh in that case.
- Parity mismatches on each half separately and on both halves. A check that crossed the halves or ignored the enable would flag the wrong bit.

// File: rtl/dram_fe_pkg.sv
`timescale 1ns/1ps
package dram_fe_pkg;
    localparam int NBANK     = 8;
    localparam int BANK_W    = $clog2(NBANK);
    localparam int WA_W      = 25;              // 64-bit-word address width (256 MB)
    localparam int WBLK_LSB  = 20;              // word-address bit of an 8 MB block
    localparam int BLK_W     = WA_W - WBLK_LSB; // 8 MB block index width
    localparam int SUM_W     = BLK_W + 1;       // block sums up to NBANK*4
    localparam int MAXBLK_W  = 2;               // largest bank spans 4 blocks
    localparam int COL_W     = 10;
    localparam int ROW_W     = WBLK_LSB + MAXBLK_W - COL_W;
    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int ACC_W     = 4;
    localparam int HOLD_W    = 4;
    localparam int IVL_W     = 16;
    localparam int TMR_W     = (ACC_W > HOLD_W) ? ACC_W : HOLD_W;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_8M   = 2'd1,
        SZ_16M  = 2'd2,
        SZ_32M  = 2'd3
    } bank_size_e;

    typedef struct packed {
        logic              err;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACC,
        ST_RCAS,
        ST_RBOTH,
        ST_RRAS
    } arb_state_e;

    function automatic logic [SUM_W-1:0] size_blocks(input logic [1:0] code);
        case (bank_size_e'(code))
            SZ_8M:   return SUM_W'(1);
            SZ_16M:  return SUM_W'(2);
            SZ_32M:  return SUM_W'(4);
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] half_parity(input logic [DATA_W-1:0] d);
        return {^d[DATA_W-1:HALF_W], ^d[HALF_W-1:0]};
    endfunction
endpackage

// File: rtl/dram_bank_map.sv
`timescale 1ns/1ps
module dram_bank_map
    import dram_fe_pkg::*;
(
    input  logic [2*NBANK-1:0] size_cfg,
    input  logic [WA_W-1:0]    waddr,
    output dec_t               dec
);
    logic [SUM_W-1:0]    blk_ext;
    logic [SUM_W-1:0]    lo;
    logic [SUM_W-1:0]    hi;
    logic [SUM_W-1:0]    sel_base;
    logic [MAXBLK_W-1:0] rel;

    assign blk_ext = {1'b0, waddr[WA_W-1:WBLK_LSB]};

    // Cumulative base per bank; the first bank whose window holds the block wins.
    always_comb begin
        lo       = '0;
        hi       = '0;
        sel_base = '0;
        dec      = '0;
        dec.err  = 1'b1;
        for (int b = 0; b < NBANK; b++) begin
            hi = lo + size_blocks(size_cfg[2*b +: 2]);
            if (dec.err && (blk_ext >= lo) && (blk_ext < hi)) begin
                dec.err  = 1'b0;
                dec.bank = BANK_W'(b);
                sel_base = lo;
            end
            lo = hi;
        end
        rel     = MAXBLK_W'(blk_ext - sel_base);
        dec.col = waddr[COL_W-1:0];
        dec.row = {rel, waddr[WBLK_LSB-1:COL_W]};
    end
endmodule

// File: rtl/dram_parity.sv
`timescale 1ns/1ps
module dram_parity
    import dram_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              par_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_par,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        rd_par,
    output logic [1:0]        par_err
);
    assign wr_par = par_en ? half_parity(wr_data) : 2'b00;

    always_ff @(posedge clk) begin
        if (rst)
            par_err <= 2'b00;
        else if (rd_valid && par_en)
            par_err <= half_parity(rd_data) ^ rd_par;
        else
            par_err <= 2'b00;
    end
endmodule

// File: rtl/dram_refresh_arb.sv
`timescale 1ns/1ps
module dram_refresh_arb
    import dram_fe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IVL_W-1:0] interval,
    input  logic [HOLD_W-1:0] hold,
    input  logic [ACC_W-1:0] acc_len,
    input  logic             req_valid,
    input  logic             req_ok,
    output logic             req_ready,
    output logic             accept,
    output logic             busy,
    output logic             ref_cas,
    output logic             ref_ras
);
    arb_state_e       state;
    logic [IVL_W-1:0] ivl_cnt;
    logic [TMR_W-1:0] tmr;
    logic             pending;
    logic             tick;
    logic             start_ref;

    assign tick      = (interval != '0) && (ivl_cnt >= interval - IVL_W'(1));
    assign start_ref = (state == ST_IDLE) && pending;
    assign req_ready = (state == ST_IDLE) && !pending;
    assign accept    = req_valid && req_ready;
    assign busy      = (state == ST_ACC);
    assign ref_cas   = (state == ST_RCAS)  || (state == ST_RBOTH);
    assign ref_ras   = (state == ST_RBOTH) || (state == ST_RRAS);

    always_ff @(posedge clk) begin
        if (rst) begin
            ivl_cnt <= '0;
            pending <= 1'b0;
        end else begin
            if (interval == '0 || tick)
                ivl_cnt <= '0;
            else
                ivl_cnt <= ivl_cnt + IVL_W'(1);
            pending <= tick || (pending && !start_ref);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pending) begin
                        state <= ST_RCAS;
                    end else if (accept && req_ok) begin
                        state <= ST_ACC;
                        tmr   <= TMR_W'(acc_len);
                    end
                end
                ST_ACC: begin
                    if (tmr <= TMR_W'(1)) state <= ST_IDLE;
                    else                  tmr   <= tmr - TMR_W'(1);
                end
                ST_RCAS: begin
                    state <= ST_RBOTH;
                    tmr   <= TMR_W'(hold);
                end
                ST_RBOTH: begin
                    if (tmr <= TMR_W'(1)) state <= ST_RRAS;
                    else                  tmr   <= tmr - TMR_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_fe_top.sv
`timescale 1ns/1ps
module dram_fe_top
    import dram_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2*NBANK-1:0]  cfg_bank_size,
    input  logic                cfg_par_en,
    input  logic [ACC_W-1:0]    cfg_acc_cycles,
    input  logic [IVL_W-1:0]    cfg_ref_interval,
    input  logic [HOLD_W-1:0]   cfg_ref_hold,
    input  logic                req_valid,
    input  logic [WA_W-1:0]     req_addr,
    output logic                req_ready,
    output logic                addr_err,
    output logic                acc_busy,
    output logic [NBANK-1:0]    acc_cs,
    output logic [BANK_W-1:0]   acc_bank,
    output logic [ROW_W-1:0]    acc_row,
    output logic [COL_W-1:0]    acc_col,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [1:0]          wr_par,
    input  logic                rd_valid,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [1:0]          rd_par,
    output logic [1:0]          par_err,
    output logic                ref_cas,
    output logic                ref_ras
);
    dec_t dec;
    logic accept;

    dram_bank_map u_map (
        .size_cfg (cfg_bank_size),
        .waddr    (req_addr),
        .dec      (dec)
    );

    dram_parity u_par (
        .clk      (clk),
        .rst      (rst),
        .par_en   (cfg_par_en),
        .wr_data  (wr_data),
        .wr_par   (wr_par),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_par   (rd_par),
        .par_err  (par_err)
    );

    dram_refresh_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .interval  (cfg_ref_interval),
        .hold      (cfg_ref_hold),
        .acc_len   (cfg_acc_cycles),
        .req_valid (req_valid),
        .req_ok    (!dec.err),
        .req_ready (req_ready),
        .accept    (accept),
        .busy      (acc_busy),
        .ref_cas   (ref_cas),
        .ref_ras   (ref_ras)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_err <= 1'b0;
            acc_bank <= '0;
            acc_row  <= '0;
            acc_col  <= '0;
        end else begin
            addr_err <= accept && dec.err;
            if (accept && !dec.err) begin
                acc_bank <= dec.bank;
                acc_row  <= dec.row;
                acc_col  <= dec.col;
            end
        end
    end

    assign acc_cs = acc_busy ? (NBANK'(1) << acc_bank) : '0;
endmodule

// File: rtl/dram_fe_checker.sv
`timescale 1ns/1ps
module dram_fe_checker
    import dram_fe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_par_en,
    input logic             req_ready,
    input logic             addr_err,
    input logic             acc_busy,
    input logic [NBANK-1:0] acc_cs,
    input logic [1:0]       wr_par,
    input logic [1:0]       par_err,
    input logic             ref_cas,
    input logic             ref_ras
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(acc_cs)); // R2
    AST_CS_WITH_BUSY: assert property (@(posedge clk) disable iff (rst) (acc_cs != '0) == acc_busy); // R2
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) addr_err |-> !acc_busy); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) acc_busy |-> !req_ready); // R4
    AST_WR_PAR_OFF: assert property (@(posedge clk) disable iff (rst) !cfg_par_en |-> (wr_par == 2'b00)); // R5
    AST_RD_PAR_OFF: assert property (@(posedge clk) disable iff (rst) !$past(cfg_par_en) |-> (par_err == 2'b00)); // R6
    AST_RAS_JOINS_CAS: assert property (@(posedge clk) disable iff (rst) $rose(ref_ras) |-> (ref_cas && $past(ref_cas))); // R8
    AST_CAS_LEAVES_FIRST: assert property (@(posedge clk) disable iff (rst) $fell(ref_ras) |-> (!ref_cas && !$past(ref_cas))); // R8
    AST_NO_STROBE_IN_ACCESS: assert property (@(posedge clk) disable iff (rst) acc_busy |-> (!ref_cas && !ref_ras)); // R9
endmodule

bind dram_fe_top dram_fe_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_par_en (cfg_par_en),
    .req_ready  (req_ready),
    .addr_err   (addr_err),
    .acc_busy   (acc_busy),
    .acc_cs     (acc_cs),
    .wr_par     (wr_par),
    .par_err    (par_err),
    .ref_cas    (ref_cas),
    .ref_ras    (ref_ras)
);

// File: tb/dram_fe_top_bench.sv
`timescale 1ns/1ps
module dram_fe_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_bank_size = 16'h0127;
    logic        cfg_par_en = 1'b1;
    logic [3:0]  cfg_acc_cycles = 4'd2;
    logic [15:0] cfg_ref_interval = 16'd0;
    logic [3:0]  cfg_ref_hold = 4'd3;
    logic        req_valid = 1'b0;
    logic [24:0] req_addr = '0;
    logic        req_ready, addr_err, acc_busy;
    logic [7:0]  acc_cs;
    logic [2:0]  acc_bank;
    logic [11:0] acc_row;
    logic [9:0]  acc_col;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_par;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [1:0]  rd_par = '0;
    logic [1:0]  par_err;
    logic        ref_cas, ref_ras;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_fe_top u_dram_fe_top (.*);

    typedef struct packed {
        logic [27:0] a;
        logic        err;
        logic [2:0]  bank;
        logic [11:0] row;
        logic [9:0]  col;
    } vec_t;

    // Map 0x127: bank0 32MB, bank1 8MB, bank2 16MB, bank3 empty, bank4 8MB.
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{28'h0000000, 1'b0, 3'd0, 12'h000, 10'h000},
        '{28'h1FFFFF8, 1'b0, 3'd0, 12'hFFF, 10'h3FF},
        '{28'h2000000, 1'b0, 3'd1, 12'h000, 10'h000},
        '{28'h2000018, 1'b0, 3'd1, 12'h000, 10'h003},
        '{28'h2800000, 1'b0, 3'd2, 12'h000, 10'h000},
        '{28'h2802008, 1'b0, 3'd2, 12'h001, 10'h001},
        '{28'h37FFFF8, 1'b0, 3'd2, 12'h7FF, 10'h3FF},
        '{28'h3800000, 1'b0, 3'd4, 12'h000, 10'h000},
        '{28'h3FFFFF8, 1'b0, 3'd4, 12'h3FF, 10'h3FF},
        '{28'h4000000, 1'b1, 3'd0, 12'h000, 10'h000},
        '{28'hFFFFFF8, 1'b1, 3'd0, 12'h000, 10'h000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Issue one request; returns at the negedge after acceptance.
    task automatic issue(input logic [27:0] byte_addr);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = byte_addr[27:3];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (acc_busy && n < 40) begin
            n++;
            check(!req_ready, "R4 ready low while busy", 32'(req_ready), 0);
            @(negedge clk);
        end
    endtask

    task automatic wait_cas_rise(output int t, output bit ok);
        logic prev;
        ok   = 1'b0;
        t    = 0;
        prev = ref_cas;
        for (int i = 0; i < 600 && !ok; i++) begin
            @(negedge clk);
            if (ref_cas && !prev) begin
                ok = 1'b1;
                t  = cyc;
            end
            prev = ref_cas;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        int t1, t2, rises;
        bit ok;
        logic prev;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 req_ready", 32'(req_ready), 1);
        check({addr_err, acc_busy, acc_cs, ref_cas, ref_ras, par_err} == '0, "R10 outputs low",
              32'({addr_err, acc_busy, acc_cs, ref_cas, ref_ras, par_err}), 0);

        // Table walk: R1/R2/R3/R4
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].a);
            check(addr_err == VEC[i].err, "R3 addr_err", 32'(addr_err), 32'(VEC[i].err));
            if (!VEC[i].err) begin
                check(acc_bank == VEC[i].bank, "R1 bank", 32'(acc_bank), 32'(VEC[i].bank));
                check(acc_row == VEC[i].row, "R2 row", 32'(acc_row), 32'(VEC[i].row));
                check(acc_col == VEC[i].col, "R2 col", 32'(acc_col), 32'(VEC[i].col));
                check(acc_cs == (8'd1 << VEC[i].bank), "R2 cs", 32'(acc_cs), 32'(8'd1 << VEC[i].bank));
                busy_len(n);
                check(n == 2, "R4 busy length 2", 32'(n), 2);
            end else begin
                check(!acc_busy && acc_cs == 0, "R3 no access", 32'({acc_busy, acc_cs}), 0);
                @(negedge clk);
                check(!addr_err, "R3 single pulse", 32'(addr_err), 0);
            end
        end

        // R1 fully populated map, R4 zero length acts as one
        cfg_bank_size  = 16'hFFFF;
        cfg_acc_cycles = 4'd0;
        issue(28'hFFFFFF8);
        check(!addr_err && acc_bank == 3'd7, "R1 full map top bank", 32'(acc_bank), 7);
        check(acc_row == 12'hFFF && acc_col == 10'h3FF, "R2 full map row/col", 32'({acc_row, acc_col}), 32'h3FFFFF);
        busy_len(n);
        check(n == 1, "R4 busy length min", 32'(n), 1);
        cfg_bank_size  = 16'h0127;
        cfg_acc_cycles = 4'd2;

        // Parity R5/R6
        @(negedge clk);
        wr_data = 64'h00000001_00000003;
        #1 check(wr_par == 2'b10, "R5 wr_par a", 32'(wr_par), 2);
        wr_data = 64'hFFFFFFFF_00000000;
        #1 check(wr_par == 2'b00, "R5 wr_par b", 32'(wr_par), 0);
        wr_data = 64'h80000000_00000001;
        #1 check(wr_par == 2'b11, "R5 wr_par c", 32'(wr_par), 3);
        @(negedge clk);
        rd_valid = 1'b1; rd_data = 64'h00000001_00000003; rd_par = 2'b00;
        @(negedge clk);
        check(par_err == 2'b10, "R6 high half mismatch", 32'(par_err), 2);
        rd_par = 2'b10;
        @(negedge clk);
        check(par_err == 2'b00, "R6 match", 32'(par_err), 0);
        rd_par = 2'b01;
        @(negedge clk);
        check(par_err == 2'b11, "R6 both halves", 32'(par_err), 3);
        rd_data = 64'h00000000_00000001; rd_par = 2'b00;
        @(negedge clk);
        check(par_err == 2'b01, "R6 low half mismatch", 32'(par_err), 1);
        rd_valid = 1'b0; rd_par = 2'b11;
        @(negedge clk);
        check(par_err == 2'b00, "R6 no rd_valid", 32'(par_err), 0);
        cfg_par_en = 1'b0; rd_valid = 1'b1;
        wr_data = 64'h80000000_00000001;
        #1 check(wr_par == 2'b00, "R5 disabled", 32'(wr_par), 0);
        @(negedge clk);
        check(par_err == 2'b00, "R6 disabled", 32'(par_err), 0);
        rd_valid = 1'b0; cfg_par_en = 1'b1;

        // Refresh sequence and interval R7/R8
        cfg_ref_hold = 4'd3;
        cfg_ref_interval = 16'd40;
        wait_cas_rise(t1, ok);
        check(ok, "R7 refresh occurs", 32'(ok), 1);
        check(!ref_ras, "R8 CAS alone first", 32'(ref_ras), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(ref_cas && ref_ras, "R8 both held", 32'({ref_cas, ref_ras}), 3);
        end
        @(negedge clk);
        check(!ref_cas && ref_ras, "R8 RAS alone", 32'({ref_cas, ref_ras}), 1);
        @(negedge clk);
        check(!ref_cas && !ref_ras, "R8 both released", 32'({ref_cas, ref_ras}), 0);
        wait_cas_rise(t2, ok);
        check(ok && (t2 - t1) == 40, "R7 interval spacing", 32'(t2 - t1), 40);

        cfg_ref_hold = 4'd0;
        wait_cas_rise(t1, ok);
        @(negedge clk);
        check(ref_cas && ref_ras, "R8 zero hold both", 32'({ref_cas, ref_ras}), 3);
        @(negedge clk);
        check(!ref_cas && ref_ras, "R8 zero hold one cycle", 32'({ref_cas, ref_ras}), 1);
        cfg_ref_hold = 4'd3;

        // R9: requests held high, refresh must still win between accesses
        cfg_acc_cycles = 4'd15;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = '0;
        rises = 0;
        prev = ref_cas;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (acc_busy && (ref_cas || ref_ras)) n++;
            if (ref_cas && !prev) rises++;
            prev = ref_cas;
        end
        req_valid = 1'b0;
        check(n == 0, "R9 no strobe during access", 32'(n), 0);
        check(rises >= 5, "R9 refresh wins over held request", 32'(rises), 5);
        cfg_acc_cycles = 4'd2;

        // R7 interval zero disables
        cfg_ref_interval = 16'd0;
        repeat (80) @(negedge clk);
        rises = 0;
        prev = ref_cas;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (ref_cas && !prev) rises++;
            prev = ref_cas;
        end
        check(rises == 0, "R7 zero interval disables", 32'(rises), 0);

        finish_up();
    end
endmodule